// File: doc/BRIEF.md
# SDLC Frame Transmitter with Sync Preamble

This block turns a stream of bytes from a host into one bit-serial SDLC frame. A frame can start with a two-byte sync preamble. Then come an opening flag, the address byte, an optional control byte, the information bytes, an optional 16-bit frame check sequence and a closing flag. The block sends one line bit for each cycle in which `bitEn` is high, so an external baud divider or recovered clock sets the line rate.

A mode byte, written while the transmitter is idle, sets four options:
- the line coding, NRZ or NRZI;
- whether a control byte is present;
- whether the check sequence is appended;
- whether the sync preamble is sent.

The preamble byte follows the line coding, so the remote clock-recovery logic always gets a dense run of edges ahead of the opening flag.

The host loads a mode, pulses `start`, and then offers bytes on `dataIn`/`dataValid`. The block takes a byte exactly in the cycle it needs one, and marks that cycle with `dataReady`. The information field ends at the first byte boundary where `dataValid` is low. `done` pulses once when the closing flag has left the line.

Top module: `sdlc_frame_tx`

## Requirements
- R1: After reset `txd` is 1, and `busy`, `done` and `dataReady` are 0.
- R2: In NRZ mode (mode bit 4 = 0) a frame goes out as flag 7Eh, the address byte, the control byte, the information bytes, the check sequence and flag 7Eh. Every byte is sent least significant bit first, and `txd` equals the data bit.
- R3: The check sequence is a reflected CRC-16 over the address, control and information bytes. It uses polynomial x^16+x^12+x^5+1 (reflected constant 8408h) with preset FFFFh. It is sent inverted, low byte first.
- R4: With mode bit 4 = 1 the line is NRZI-coded: a 0 bit inverts `txd` and a 1 bit keeps it. Coding continues from whatever level the line holds.
- R5: With mode bit 2 = 1, two preamble bytes precede the opening flag. They are 00h in NRZI mode and 55h in NRZ mode, and no zeros are inserted into them.
- R6: With mode bit 1 = 1 no control byte is sent, and information bytes follow the address only while `dataValid` is high. With mode bit 1 = 0 the byte after the address is always taken as control.
- R7: With mode bit 0 = 1 no check sequence is sent, and the closing flag follows the last data byte.
- R8: From the address through the check sequence, a 0 is inserted after every five consecutive 1s. This includes a run that ends right before the closing flag. Flags and preamble are never stuffed.
- R9: A mode write or `start` while `busy` is 1 has no effect on the running frame or on later frames.
- R10: `txd` changes only in a cycle that follows an active `bitEn` while busy. Between frames it holds its level.
- R11: `dataReady` is high for exactly one cycle per byte taken, only together with `bitEn`. Each offered byte is taken once.
- R12: `done` is a single-cycle pulse in the cycle after the last closing-flag bit is driven, and `busy` falls on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One line bit is sent per cycle with this high |
| modeWe | input | 1 | Mode byte write strobe, honoured only while idle |
| modeIn | input | 8 | Mode byte: bit 4 NRZI, bit 2 preamble, bit 1 no control, bit 0 no check sequence |
| start | input | 1 | Begin a frame while idle |
| dataIn | input | 8 | Next frame byte offered by the host |
| dataValid | input | 1 | `dataIn` holds a byte to send |
| dataReady | output | 1 | The byte on `dataIn` is taken this cycle |
| txd | output | 1 | Serial line output |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Frame finished pulse |

## Verification
Every line bit is visible, so a wrong field state, a byte counter off by one or a lost stuff decision shows up at `txd` within one byte time of the error. The bench compares the whole captured bit sequence against an independently built frame. A corrupted CRC register or a lost NRZI level cannot show until the check sequence or the next 0 bit, and then it persists to the end of the frame. A mode byte that changed while busy only becomes visible in the next frame, so that frame is also compared.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_PATTERN = 8'h7E;
  localparam logic [BYTE_W-1:0] SYNC_NRZ = 8'h55;
  localparam logic [BYTE_W-1:0] SYNC_NRZI = 8'h00;

  // mode byte field positions
  localparam int M_NRZI = 4;
  localparam int M_SYNC = 2;
  localparam int M_NOCTL = 1;
  localparam int M_NOFCS = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_OPEN, ST_ADDR, ST_CTRL, ST_INFO, ST_FCS, ST_CLOSE
  } txState_t;

  typedef enum logic [2:0] {
    LD_DATA, LD_FLAG, LD_SYNC, LD_FCS_LO, LD_FCS_HI
  } loadSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     tick;     // a line bit is sent this cycle
    logic     stuff;    // the bit sent is an inserted zero
    logic     load;     // reload the shifter
    loadSel_t sel;      // source of the reload
    logic     crcInit;  // preset the CRC
    logic     crcEn;    // accumulate the outgoing bit into the CRC
    logic     zone;     // bit belongs to the stuffed region
  } dpCtl_t;
endpackage

// File: rtl/sdlc_tx_dp.sv
module sdlc_tx_dp
  import sdlc_tx_pkg::*;
#(
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              nrzi,
  output logic              bitLast,
  output logic              onesFull,
  output logic              txd
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);

  logic [BYTE_W-1:0] shReg, loadVal;
  logic [CNT_W-1:0]  bitCnt;
  logic [ONES_W-1:0] onesCnt;
  logic [CRC_W-1:0]  crc, crcNext;
  logic              lineReg, lineNext, curBit, shift;

  assign curBit = shReg[0];
  assign shift = ctl.tick && !ctl.stuff;
  assign crcNext = (crc >> 1) ^ ((crc[0] ^ curBit) ? CRC_POLY_REV : '0);

  always_comb begin
    case (ctl.sel)
      LD_DATA:   loadVal = dataIn;
      LD_SYNC:   loadVal = nrzi ? SYNC_NRZI : SYNC_NRZ;
      LD_FCS_LO: loadVal = ~crcNext[BYTE_W-1:0];
      LD_FCS_HI: loadVal = ~crc[CRC_W-1 -: BYTE_W];
      default:   loadVal = FLAG_PATTERN;
    endcase
  end

  always_comb begin
    if (ctl.stuff) lineNext = nrzi ? ~lineReg : 1'b0;
    else if (nrzi) lineNext = curBit ? lineReg : ~lineReg;
    else           lineNext = curBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '1;
      bitCnt  <= '0;
      onesCnt <= '0;
      crc     <= CRC_PRESET;
      lineReg <= 1'b1;
    end else begin
      if (ctl.tick) lineReg <= lineNext;
      if (ctl.stuff) onesCnt <= '0;
      else if (shift) onesCnt <= (ctl.zone && curBit) ? onesCnt + 1'b1 : '0;
      if (ctl.crcInit) crc <= CRC_PRESET;
      else if (shift && ctl.crcEn) crc <= crcNext;
      if (ctl.load) begin
        shReg  <= loadVal;
        bitCnt <= '0;
      end else if (shift) begin
        shReg  <= shReg >> 1;
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign bitLast = (bitCnt == CNT_W'(BYTE_W - 1));
  assign onesFull = (onesCnt == ONES_W'(STUFF_RUN));
  assign txd = lineReg;
endmodule

// File: rtl/sdlc_tx_ctrl.sv
module sdlc_tx_ctrl
  import sdlc_tx_pkg::*;
#(
  parameter int SYNC_BYTES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   bitEn,
  input  logic   dataValid,
  input  logic   modeSync,
  input  logic   modeNoCtl,
  input  logic   modeNoFcs,
  input  logic   bitLast,
  input  logic   onesFull,
  output dpCtl_t ctl,
  output logic   dataReady,
  output logic   busy,
  output logic   done
);
  localparam int CNT_W = $clog2(SYNC_BYTES + 1);

  txState_t         state, stateN, endState;
  loadSel_t         endSel;
  logic [CNT_W-1:0] cnt, cntN;
  logic             byteEnd;

  // what follows the last data byte
  always_comb begin
    if (!modeNoFcs) begin
      endState = ST_FCS;
      endSel   = LD_FCS_LO;
    end else begin
      endState = ST_CLOSE;
      endSel   = LD_FLAG;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.sel   = LD_FLAG;
    stateN    = state;
    cntN      = cnt;
    ctl.tick  = bitEn && (state != ST_IDLE);
    ctl.stuff = ctl.tick && onesFull;
    byteEnd   = ctl.tick && !onesFull && bitLast;
    ctl.zone  = state inside {ST_ADDR, ST_CTRL, ST_INFO, ST_FCS};
    ctl.crcEn = state inside {ST_ADDR, ST_CTRL, ST_INFO};
    unique case (state)
      ST_IDLE: if (start) begin
        ctl.load    = 1'b1;
        ctl.crcInit = 1'b1;
        cntN        = '0;
        stateN      = modeSync ? ST_SYNC : ST_OPEN;
        ctl.sel     = modeSync ? LD_SYNC : LD_FLAG;
      end
      ST_SYNC: if (byteEnd) begin
        ctl.load = 1'b1;
        if (cnt == CNT_W'(SYNC_BYTES - 1)) begin
          stateN  = ST_OPEN;
          ctl.sel = LD_FLAG;
        end else begin
          cntN    = cnt + 1'b1;
          ctl.sel = LD_SYNC;
        end
      end
      ST_OPEN: if (byteEnd) begin
        ctl.load = 1'b1;
        ctl.sel  = LD_DATA;
        stateN   = ST_ADDR;
      end
      ST_ADDR: if (byteEnd) begin
        ctl.load = 1'b1;
        if (!modeNoCtl) begin
          ctl.sel = LD_DATA;
          stateN  = ST_CTRL;
        end else if (dataValid) begin
          ctl.sel = LD_DATA;
          stateN  = ST_INFO;
        end else begin
          ctl.sel = endSel;
          stateN  = endState;
          cntN    = '0;
        end
      end
      ST_CTRL, ST_INFO: if (byteEnd) begin
        ctl.load = 1'b1;
        if (dataValid) begin
          ctl.sel = LD_DATA;
          stateN  = ST_INFO;
        end else begin
          ctl.sel = endSel;
          stateN  = endState;
          cntN    = '0;
        end
      end
      ST_FCS: if (byteEnd) begin
        ctl.load = 1'b1;
        if (cnt == '0) begin
          ctl.sel = LD_FCS_HI;
          cntN    = cnt + 1'b1;
        end else begin
          ctl.sel = LD_FLAG;
          stateN  = ST_CLOSE;
        end
      end
      ST_CLOSE: if (byteEnd) stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateN;
      cnt   <= cntN;
      done  <= (state == ST_CLOSE) && byteEnd;
    end
  end

  assign dataReady = ctl.load && (ctl.sel == LD_DATA) && (state != ST_IDLE);
  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sdlc_frame_tx.sv
module sdlc_frame_tx
  import sdlc_tx_pkg::*;
#(
  parameter int SYNC_BYTES = 2,
  parameter int STUFF_RUN = 5,
  parameter int CRC_W = 16,
  parameter logic [CRC_W-1:0] CRC_POLY_REV = 16'h8408,
  parameter logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        modeWe,
  input  logic [7:0]  modeIn,
  input  logic        start,
  input  logic [7:0]  dataIn,
  input  logic        dataValid,
  output logic        dataReady,
  output logic        txd,
  output logic        busy,
  output logic        done
);
  logic [7:0] modeReg;
  dpCtl_t     ctl;
  logic       bitLast, onesFull;

  always_ff @(posedge clk) begin
    if (!rstN) modeReg <= '0;
    else if (modeWe && !busy) modeReg <= modeIn;
  end

  sdlc_tx_ctrl #(.SYNC_BYTES(SYNC_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .bitEn(bitEn), .dataValid(dataValid),
    .modeSync(modeReg[M_SYNC]), .modeNoCtl(modeReg[M_NOCTL]), .modeNoFcs(modeReg[M_NOFCS]),
    .bitLast(bitLast), .onesFull(onesFull), .ctl(ctl), .dataReady(dataReady),
    .busy(busy), .done(done)
  );

  sdlc_tx_dp #(
    .CRC_W(CRC_W), .CRC_POLY_REV(CRC_POLY_REV), .CRC_PRESET(CRC_PRESET), .STUFF_RUN(STUFF_RUN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn), .nrzi(modeReg[M_NRZI]),
    .bitLast(bitLast), .onesFull(onesFull), .txd(txd)
  );
endmodule

// File: rtl/sdlc_tx_chk.sv
module sdlc_tx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic       modeWe,
  input logic [7:0] modeReg,
  input logic       dataReady,
  input logic       txd,
  input logic       busy,
  input logic       done
);
  a_r12_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  a_r12_busy_fall_done: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  a_r12_done_idle: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN) !busy |=> $stable(txd));
  a_r10_no_enable_hold: assert property (@(posedge clk) disable iff (!rstN) !bitEn |=> $stable(txd));
  a_r11_ready_on_tick: assert property (@(posedge clk) disable iff (!rstN) dataReady |-> (bitEn && busy));
  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rstN) (modeWe && busy) |=> $stable(modeReg));
endmodule

bind sdlc_frame_tx sdlc_tx_chk i_sdlc_tx_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeWe(modeWe), .modeReg(modeReg),
  .dataReady(dataReady), .txd(txd), .busy(busy), .done(done)
);

// File: tb/test_sdlc_frame_tx.sv
module test_sdlc_frame_tx;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0, bitEn = 1'b0, modeWe = 1'b0, start = 1'b0;
  logic [7:0] modeIn = '0, dataIn;
  logic       dataValid, dataReady, txd, busy, done;

  sdlc_frame_tx i_sdlc_frame_tx (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .modeWe(modeWe), .modeIn(modeIn), .start(start),
    .dataIn(dataIn), .dataValid(dataValid), .dataReady(dataReady), .txd(txd), .busy(busy), .done(done)
  );

  int testsRun = 0, testsFailed = 0;
  int density = 100;
  logic [7:0] frameBytes [64];
  int frameLen = 0, idx = 0, doneCount = 0, onesRun = 0;
  logic idxClr = 1'b0, armed = 1'b0, expLine = 1'b1;
  bit gotBits[$];
  bit expBits[$];

  assign dataValid = (idx < frameLen);
  assign dataIn = dataValid ? frameBytes[idx] : 8'h00;

  always @(posedge clk) begin
    if (idxClr) idx <= 0;
    else if (dataReady) idx <= idx + 1;
  end

  // capture one line bit per enabled tick, and drive the next enable
  always @(negedge clk) begin
    if (armed) gotBits.push_back(txd);
    if (done) doneCount = doneCount + 1;
    bitEn = ($urandom_range(0, 99) < density);
    armed = bitEn && busy;
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected stream builders, from the requirements
  task automatic pushLine(input bit b, input bit nrzi);
    expLine = nrzi ? (b ? expLine : ~expLine) : b;
    expBits.push_back(expLine);
  endtask

  task automatic emitByte(input logic [7:0] b, input bit zone, input bit nrzi);
    for (int i = 0; i < 8; i++) begin
      pushLine(b[i], nrzi);
      if (zone) begin
        onesRun = b[i] ? onesRun + 1 : 0;
        if (onesRun == 5) begin
          pushLine(1'b0, nrzi);
          onesRun = 0;
        end
      end else onesRun = 0;
    end
  endtask

  function automatic logic [15:0] fcsOf();
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < frameLen; i++)
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ frameBytes[i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  task automatic buildExpected(input logic [7:0] mode);
    logic [15:0] f;
    bit nrzi = mode[4];
    expBits.delete();
    onesRun = 0;
    if (mode[2]) begin
      emitByte(nrzi ? 8'h00 : 8'h55, 1'b0, nrzi);
      emitByte(nrzi ? 8'h00 : 8'h55, 1'b0, nrzi);
    end
    emitByte(8'h7E, 1'b0, nrzi);
    for (int i = 0; i < frameLen; i++) emitByte(frameBytes[i], 1'b1, nrzi);
    if (!mode[0]) begin
      f = fcsOf();
      emitByte(f[7:0], 1'b1, nrzi);
      emitByte(f[15:8], 1'b1, nrzi);
    end
    emitByte(8'h7E, 1'b0, nrzi);
  endtask

  task automatic runFrame(input logic [7:0] mode, input bit writeMode, input bit disturb, input string req);
    int waitCyc = 0;
    int firstBad = -1;
    if (writeMode) begin
      @(negedge clk); modeWe = 1'b1; modeIn = mode;
      @(negedge clk); modeWe = 1'b0;
    end
    buildExpected(mode);
    @(negedge clk); idxClr = 1'b1;
    @(negedge clk); idxClr = 1'b0; gotBits.delete(); doneCount = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (doneCount == 0 && waitCyc < 20000) begin
      @(negedge clk);
      waitCyc++;
      if (disturb && waitCyc == 40) begin
        modeWe = 1'b1; modeIn = ~mode; start = 1'b1;
      end else if (disturb && waitCyc == 41) begin
        modeWe = 1'b0; start = 1'b0;
      end
    end
    repeat (4) @(negedge clk);
    check(doneCount == 1, "R12", "done pulses", doneCount, 1);
    check(gotBits.size() == expBits.size(), req, "frame bit count", gotBits.size(), expBits.size());
    for (int i = 0; i < gotBits.size() && i < expBits.size(); i++)
      if (gotBits[i] != expBits[i] && firstBad < 0) firstBad = i;
    check(firstBad < 0, req, "first mismatching bit index", firstBad, -1);
    check(idx == frameLen, "R11", "bytes taken", idx, frameLen);
    check(!busy, "R12", "busy after done", busy, 0);
    if (gotBits.size() > 0) expLine = gotBits[gotBits.size() - 1];
  endtask

  task automatic setBytes(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                          input logic [7:0] b3, input int n);
    frameBytes[0] = b0; frameBytes[1] = b1; frameBytes[2] = b2; frameBytes[3] = b3;
    frameLen = n;
  endtask

  initial begin
    logic held;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    check(txd == 1'b1 && !busy && !done && !dataReady, "R1", "reset outputs",
          {txd, busy, done, dataReady}, 4'b1000);
    rstN = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && !busy, "R1", "idle after reset", {txd, busy}, 2'b10);

    density = 100;
    setBytes(8'h03, 8'h3F, 8'h11, 8'h22, 4);
    runFrame(8'h00, 1'b1, 1'b0, "R2");
    density = 60;
    setBytes(8'hC1, 8'h00, 8'h5A, 8'h80, 4);
    runFrame(8'h00, 1'b1, 1'b0, "R3");
    runFrame(8'h10, 1'b1, 1'b0, "R4");
    runFrame(8'h14, 1'b1, 1'b0, "R5");
    runFrame(8'h04, 1'b1, 1'b0, "R5");
    setBytes(8'h47, 8'h00, 8'h00, 8'h00, 1);
    runFrame(8'h02, 1'b1, 1'b0, "R6");
    setBytes(8'h47, 8'h12, 8'h34, 8'h56, 4);
    runFrame(8'h12, 1'b1, 1'b0, "R6");
    runFrame(8'h01, 1'b1, 1'b0, "R7");
    runFrame(8'h03, 1'b1, 1'b0, "R7");
    setBytes(8'hFF, 8'hFF, 8'h7E, 8'h1F, 4);
    runFrame(8'h00, 1'b1, 1'b0, "R8");
    setBytes(8'h21, 8'h3E, 8'h00, 8'hF8, 4);
    runFrame(8'h01, 1'b1, 1'b0, "R8");
    runFrame(8'h15, 1'b1, 1'b0, "R8");
    setBytes(8'h55, 8'hAA, 8'h0F, 8'hF0, 4);
    runFrame(8'h10, 1'b1, 1'b1, "R9");
    runFrame(8'h10, 1'b0, 1'b0, "R9");

    // line must hold between frames even with bitEn active
    density = 100;
    @(negedge clk); held = txd;
    repeat (20) @(negedge clk);
    check(txd == held, "R10", "idle line level", txd, held);

    for (int f = 0; f < 24; f++) begin
      logic [7:0] mode = 8'($urandom_range(0, 255));
      int n = mode[1] ? $urandom_range(1, 12) : $urandom_range(2, 12);
      for (int i = 0; i < n; i++)
        frameBytes[i] = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 255));
      frameLen = n;
      density = $urandom_range(30, 100);
      runFrame(mode, 1'b1, 1'b0, "R10");
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule